// File: doc/BRIEF.md
# Segment Access Verification Unit

This unit judges a segment selector against the descriptor it refers to. On a request strobe it performs one of four operations: a read-access verify, a write-access verify, a privilege-raising adjustment of the selector's requested privilege level (RPL), or the privilege test made when a selector is loaded into a segment register. The descriptor access byte and the descriptor table limit are supplied on input ports by the surrounding logic. The unit does not touch descriptor memory.

A verify reports success on the zero-flag output. An adjust returns the rewritten selector, and its zero flag shows whether the RPL moved. A load reports a protection fault. Every result is registered. It is valid in the cycle after the strobe, and `done_o` pulses for that one cycle. Results hold their values until the next request.

Top module: `seg_access_unit`

## Requirements
- R1: `done_o` rises in the cycle after each cycle with `req_i` high and is low otherwise. When `req_i` is low, `zf_o`, `sel_o` and `fault_o` keep their values.
- R2: A verify (`op_i` 0 = read, 1 = write) fails with `zf_o`=0 when `{sel_i[15:3],3'b111}` is greater than `limit_i`.
- R3: A verify fails when access byte bit 4 is 0, which marks a control descriptor rather than a segment descriptor.
- R4: For data segments (bit 3 = 0) and non-conforming code segments (bit 3 = 1, bit 2 = 0), a verify needs DPL (`acc_i[6:5]`) to be greater than or equal to both `cpl_i` and the RPL (`sel_i[1:0]`).
- R5: A read verify of a code segment needs readable bit 1 set. A conforming code segment (bit 2 set) skips the privilege test on read.
- R6: A read verify of a data segment needs no access bit. A write verify of a data segment needs writable bit 1 set.
- R7: A write verify of any code segment always returns `zf_o`=0.
- R8: An adjust (`op_i`=2) returns `sel_o` with bits [15:2] of `sel_i` and RPL equal to the larger of `sel_i[1:0]` and `ref_sel_i[1:0]`.
- R9: An adjust sets `zf_o` when the RPL changed and clears it otherwise.
- R10: A load (`op_i`=3) sets `fault_o` exactly when `sel_i[1:0]` is greater than `acc_i[6:5]`, and clears `zf_o`. All other operations clear `fault_o`.
- R11: After reset `done_o`, `zf_o`, `fault_o` and `sel_o` are all zero.
- R12: For operations other than adjust, `sel_o` captures `sel_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per operation |
| op_i | input | 2 | Operation: 0 read verify, 1 write verify, 2 adjust, 3 load |
| sel_i | input | 16 | Selector under test |
| ref_sel_i | input | 16 | Reference selector for adjust |
| cpl_i | input | 2 | Current privilege level |
| acc_i | input | 8 | Descriptor access byte |
| limit_i | input | 16 | Descriptor table limit in bytes |
| done_o | output | 1 | Result valid pulse |
| zf_o | output | 1 | Zero-flag result |
| fault_o | output | 1 | Protection fault on load |
| sel_o | output | 16 | Result selector |

## Verification
The assertions assume that the inputs are stable and defined at each clock edge where `req_i` is high. They also assume that `op_i` holds only the four listed codes, which a 2-bit field guarantees. The bench drives every input on the falling edge, so each request is sampled whole. It mixes directed corner cases (limit edge, control descriptors, conforming code, equal and unequal RPLs) with random access bytes, limits and selectors, and it inserts idle cycles so that the held-output behaviour is exercised as well.

// File: rtl/seg_access_pkg.sv
package seg_access_pkg;
  typedef enum logic [1:0] {
    OP_VRD  = 2'd0,
    OP_VWR  = 2'd1,
    OP_ADJ  = 2'd2,
    OP_LOAD = 2'd3
  } sa_op_e;

  localparam int unsigned ACC_SEG_BIT  = 4;
  localparam int unsigned ACC_CODE_BIT = 3;
  localparam int unsigned ACC_CONF_BIT = 2;
  localparam int unsigned ACC_RW_BIT   = 1;
  localparam int unsigned ACC_DPL_LSB  = 5;
endpackage

// File: rtl/sa_bounds.sv
module sa_bounds #(
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned IDX_LSB = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] limit_i,
  output logic             in_bounds_o
);
  logic [SEL_W-1:0] last_byte;
  // last byte of the addressed entry
  assign last_byte   = {sel_i[SEL_W-1:IDX_LSB], {IDX_LSB{1'b1}}};
  assign in_bounds_o = (last_byte <= limit_i);
endmodule

// File: rtl/sa_rights.sv
module sa_rights
  import seg_access_pkg::*;
#(
  parameter int unsigned PL_W = 2
) (
  input  logic [7:0]      acc_i,
  input  logic [PL_W-1:0] rpl_i,
  input  logic [PL_W-1:0] cpl_i,
  output logic [PL_W-1:0] dpl_o,
  output logic            is_seg_o,
  output logic            rd_ok_o,
  output logic            wr_ok_o
);
  logic is_code, is_conf, rw_bit, pl_ok;

  assign dpl_o    = acc_i[ACC_DPL_LSB +: PL_W];
  assign is_seg_o = acc_i[ACC_SEG_BIT];
  assign is_code  = acc_i[ACC_CODE_BIT];
  assign is_conf  = acc_i[ACC_CONF_BIT];
  assign rw_bit   = acc_i[ACC_RW_BIT];
  assign pl_ok    = (dpl_o >= cpl_i) && (dpl_o >= rpl_i);

  always_comb begin
    if (is_code) begin
      rd_ok_o = rw_bit && (is_conf || pl_ok);
      wr_ok_o = 1'b0;
    end else begin
      rd_ok_o = pl_ok;
      wr_ok_o = rw_bit && pl_ok;
    end
  end
endmodule

// File: rtl/sa_rpl_adj.sv
module sa_rpl_adj #(
  parameter int unsigned SEL_W = 16,
  parameter int unsigned PL_W  = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] ref_sel_i,
  output logic [SEL_W-1:0] sel_adj_o,
  output logic             changed_o
);
  logic [PL_W-1:0] own_rpl, ref_rpl;
  assign own_rpl   = sel_i[PL_W-1:0];
  assign ref_rpl   = ref_sel_i[PL_W-1:0];
  assign changed_o = ref_rpl > own_rpl;
  assign sel_adj_o = changed_o ? {sel_i[SEL_W-1:PL_W], ref_rpl} : sel_i;
endmodule

// File: rtl/seg_access_unit.sv
module seg_access_unit
  import seg_access_pkg::*;
#(
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned PL_W    = 2,
  parameter int unsigned IDX_LSB = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       op_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] ref_sel_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  logic [7:0]       acc_i,
  input  logic [SEL_W-1:0] limit_i,
  output logic             done_o,
  output logic             zf_o,
  output logic             fault_o,
  output logic [SEL_W-1:0] sel_o
);
  logic             in_bounds, is_seg, rd_ok, wr_ok, rpl_changed;
  logic [PL_W-1:0]  dpl;
  logic [SEL_W-1:0] sel_adj;
  logic             zf_d, fault_d;
  logic [SEL_W-1:0] sel_d;
  sa_op_e           op;

  assign op = sa_op_e'(op_i);

  sa_bounds #(.SEL_W(SEL_W), .IDX_LSB(IDX_LSB)) u_bounds (
    .sel_i(sel_i), .limit_i(limit_i), .in_bounds_o(in_bounds)
  );

  sa_rights #(.PL_W(PL_W)) u_rights (
    .acc_i(acc_i), .rpl_i(sel_i[PL_W-1:0]), .cpl_i(cpl_i),
    .dpl_o(dpl), .is_seg_o(is_seg), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
  );

  sa_rpl_adj #(.SEL_W(SEL_W), .PL_W(PL_W)) u_adj (
    .sel_i(sel_i), .ref_sel_i(ref_sel_i),
    .sel_adj_o(sel_adj), .changed_o(rpl_changed)
  );

  always_comb begin
    zf_d    = 1'b0;
    fault_d = 1'b0;
    sel_d   = sel_i;
    unique case (op)
      OP_VRD:  zf_d = in_bounds && is_seg && rd_ok;
      OP_VWR:  zf_d = in_bounds && is_seg && wr_ok;
      OP_ADJ: begin
        zf_d  = rpl_changed;
        sel_d = sel_adj;
      end
      OP_LOAD: fault_d = sel_i[PL_W-1:0] > dpl;
      default: zf_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      zf_o    <= 1'b0;
      fault_o <= 1'b0;
      sel_o   <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        zf_o    <= zf_d;
        fault_o <= fault_d;
        sel_o   <= sel_d;
      end
    end
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk #(
  parameter int unsigned SEL_W = 16,
  parameter int unsigned PL_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [1:0]       op_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [SEL_W-1:0] ref_sel_i,
  input logic [7:0]       acc_i,
  input logic [SEL_W-1:0] limit_i,
  input logic             done_o,
  input logic             zf_o,
  input logic             fault_o,
  input logic [SEL_W-1:0] sel_o
);
  p_done_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && $stable(zf_o) && $stable(sel_o) && $stable(fault_o)));
  p_oob_fails_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !op_i[1] && ({sel_i[SEL_W-1:3], 3'b111} > limit_i)) |=> !zf_o);
  p_ctrl_desc_fails_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !op_i[1] && !acc_i[4]) |=> !zf_o);
  p_code_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'd1 && acc_i[3]) |=> !zf_o);
  p_adj_rpl_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'd2) |=>
      (sel_o[PL_W-1:0] >= $past(sel_i[PL_W-1:0]) &&
       sel_o[PL_W-1:0] >= $past(ref_sel_i[PL_W-1:0]) &&
       sel_o[SEL_W-1:PL_W] == $past(sel_i[SEL_W-1:PL_W])));
  p_fault_only_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i != 2'd3) |=> !fault_o);
  p_load_zf_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'd3) |=> !zf_o);
  p_sel_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i != 2'd2) |=> sel_o == $past(sel_i));
endmodule

bind seg_access_unit seg_access_chk #(.SEL_W(SEL_W), .PL_W(PL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i),
  .sel_i(sel_i), .ref_sel_i(ref_sel_i), .acc_i(acc_i), .limit_i(limit_i),
  .done_o(done_o), .zf_o(zf_o), .fault_o(fault_o), .sel_o(sel_o)
);

// File: tb/tb_seg_access_unit.sv
module tb_seg_access_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] sel = '0, ref_sel = '0, limit = '0;
  logic [1:0]  cpl = '0;
  logic [7:0]  acc = '0;
  logic        done, zf, fault;
  logic [15:0] sel_out;

  int n_chk = 0, n_fail = 0;
  bit m_done = 0, m_zf = 0, m_fault = 0;
  int m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_access_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .sel_i(sel),
    .ref_sel_i(ref_sel), .cpl_i(cpl), .acc_i(acc), .limit_i(limit),
    .done_o(done), .zf_o(zf), .fault_o(fault), .sel_o(sel_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference evaluated from the requirements
  task automatic model_step();
    int rpl, rrpl, dpl, idx_end;
    bit seg, code, conf, rw, plok, ok;
    m_done = req;
    if (!req) return;
    rpl = sel % 4; rrpl = ref_sel % 4; dpl = (acc / 32) % 4;
    idx_end = (sel / 8) * 8 + 7;
    seg = acc[4]; code = acc[3]; conf = acc[2]; rw = acc[1];
    plok = (dpl >= cpl) && (dpl >= rpl);
    m_fault = 0; m_zf = 0; m_sel = sel;
    case (op)
      0: begin
        ok = code ? (rw && (conf || plok)) : plok;
        m_zf = (idx_end <= limit) && seg && ok;
      end
      1: m_zf = (idx_end <= limit) && seg && !code && rw && plok;
      2: begin
        m_zf = rrpl > rpl;
        m_sel = (sel / 4) * 4 + ((rrpl > rpl) ? rrpl : rpl);
      end
      default: m_fault = rpl > dpl;
    endcase
  endtask

  function automatic string tag_of(logic [1:0] o);
    case (o)
      0: return "R4/R5/R6 read verify";
      1: return "R6/R7 write verify";
      2: return "R8/R9 adjust";
      default: return "R10 load";
    endcase
  endfunction

  logic [1:0] last_op = '0;

  task automatic cyc(bit r, logic [1:0] o, logic [15:0] s, logic [15:0] rs,
                     logic [1:0] c, logic [7:0] a, logic [15:0] l);
    @(negedge clk);
    req = r; op = o; sel = s; ref_sel = rs; cpl = c; acc = a; limit = l;
    @(posedge clk);
    model_step();
    if (r) last_op = o;
    #1;
    chk("R1 done", int'(done), int'(m_done));
    chk({tag_of(last_op), " zf"}, int'(zf), int'(m_zf));
    chk("R10/R12 fault", int'(fault), int'(m_fault));
    chk("R8/R12 sel", int'(sel_out), m_sel);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R11 reset state
    chk("R11 done", int'(done), 0);
    chk("R11 zf", int'(zf), 0);
    chk("R11 fault", int'(fault), 0);
    chk("R11 sel", int'(sel_out), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 bounds edge: index 4 -> last byte 39
    cyc(1, 0, 16'h0020, 0, 0, 8'h12, 16'd39);  // pass
    cyc(1, 0, 16'h0020, 0, 0, 8'h12, 16'd38);  // fail
    cyc(0, 0, 16'h0000, 0, 0, 8'h00, 16'd0);   // R1 idle hold
    // R3 control descriptor
    cyc(1, 0, 16'h0008, 0, 0, 8'h62, 16'hFFFF);
    // R4 data privilege: DPL 1, CPL 2 -> fail; DPL 3 -> pass; RPL 3 vs DPL 2 -> fail
    cyc(1, 0, 16'h0008, 0, 2, 8'h32, 16'hFFFF);
    cyc(1, 0, 16'h0008, 0, 2, 8'h72, 16'hFFFF);
    cyc(1, 0, 16'h000B, 0, 0, 8'h52, 16'hFFFF);
    // R5 conforming code DPL 0, CPL 3 read -> pass; unreadable code -> fail
    cyc(1, 0, 16'h000B, 0, 3, 8'h1E, 16'hFFFF);
    cyc(1, 0, 16'h0008, 0, 0, 8'h7C, 16'hFFFF);
    cyc(1, 0, 16'h000B, 0, 3, 8'h1A, 16'hFFFF); // non-conforming, fails
    // R6 data write: writable pass, read-only fail
    cyc(1, 1, 16'h0008, 0, 0, 8'h72, 16'hFFFF);
    cyc(1, 1, 16'h0008, 0, 0, 8'h70, 16'hFFFF);
    // R7 code never writable
    cyc(1, 1, 16'h0008, 0, 0, 8'h7A, 16'hFFFF);
    cyc(1, 1, 16'h0008, 0, 0, 8'h7E, 16'hFFFF);
    // R8/R9 adjust raise, equal, lower
    cyc(1, 2, 16'h1231, 16'h0003, 0, 0, 0);
    cyc(1, 2, 16'h1232, 16'h0002, 0, 0, 0);
    cyc(1, 2, 16'h1233, 16'h0001, 0, 0, 0);
    // R10 load
    cyc(1, 3, 16'h0003, 0, 0, 8'h40, 0);
    cyc(1, 3, 16'h0002, 0, 0, 8'h40, 0);
    cyc(0, 3, 16'h0003, 0, 0, 8'h00, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) != 0, 2'($urandom), 16'($urandom), 16'($urandom),
          2'($urandom), 8'($urandom), 16'($urandom % 512));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule